// File: doc/BRIEF.md
# Transfer Packet Splitter with Media Alignment Check

This block sits at the front of a transfer engine. It takes one packet command at a time, made of a source address, a destination address, a byte length and a media type for each side. Each side is either external memory or on-chip SRAM. The block breaks the packet into bus requests of at most 256 bytes each. Every piece except the last carries exactly 256 bytes, and both addresses move forward by 256 bytes from one piece to the next.

Before it issues anything, the block checks the command against the alignment rules of the chosen media pair and against the length limits. A command that breaks a rule issues no request. It sets a sticky error flag, and the block is ready for the next command on the following cycle. Commands arrive on a valid/ready port and pieces leave on another.

Top module: `dma_pkt_splitter`

## Requirements
- R1: A packet of n bytes, with 1 <= n <= 4096, is issued as exactly ceil(n/256) requests. A 4095-byte packet gives 16 requests.
- R2: Within one packet, the first request carries the command's source and destination addresses. Each later request carries both addresses increased by 256, modulo 2^32.
- R3: A length above 4096 bytes is rejected. A length of exactly 4096 is accepted.
- R4: A length of zero is rejected.
- R5: When the destination is on-chip SRAM (`cmd_dst_ext` = 0), a command is rejected if the destination address or the length is not a multiple of 8.
- R6: Source addresses from either media, and destination addresses in external memory (`cmd_dst_ext` = 1), need only 1-byte alignment. If the length rules hold, such commands are never rejected.
- R7: When the source is external memory (`cmd_src_ext` = 1) and the destination is on-chip SRAM, the source address must also be a multiple of 8, or the command is rejected.
- R8: A rejected command issues no request and sets `err_flag`, which stays at 1 until reset. `cmd_ready` is 1 again in the cycle after the rejection.
- R9: While a packet is being issued, `cmd_ready` is 0. While `req_valid` is 1 and `req_ready` is 0, every request output holds its value.
- R10: Every request except the last of its packet has `req_len` = 256 and `req_last` = 0. The last request has `req_last` = 1 and carries the remaining bytes, n - 256*(ceil(n/256)-1).
- R11: After reset, `cmd_ready` = 1, `req_valid` = 0 and `err_flag` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken when high together with cmd_valid |
| cmd_src_addr | input | 32 | Byte address the packet is read from |
| cmd_dst_addr | input | 32 | Byte address the packet is written to |
| cmd_len | input | 13 | Packet length in bytes |
| cmd_src_ext | input | 1 | 1: source is external memory, 0: on-chip SRAM |
| cmd_dst_ext | input | 1 | 1: destination is external memory, 0: on-chip SRAM |
| req_valid | output | 1 | Request piece offered |
| req_ready | input | 1 | Request piece taken when high together with req_valid |
| req_src_addr | output | 32 | Source address of this piece |
| req_dst_addr | output | 32 | Destination address of this piece |
| req_len | output | 9 | Bytes in this piece, 1 to 256 |
| req_last | output | 1 | Final piece of the packet |
| err_flag | output | 1 | Sticky rejection flag |

## Verification
The hardest state to reach from the ports is the moment after a rejection. The flag is sticky, so a second violation leaves no visible trace unless the block starts from a clean reset. The bench therefore resets before every alignment case. It sweeps all four media pairings against every low-three-bit offset of both addresses and against aligned and unaligned lengths. It also sends a valid packet right after a rejection to show that the port accepts commands again. The piece boundaries are covered by sweeping every length from 1 to 4096 while `req_ready` stalls in a repeating pattern, so that held requests and last pieces of every size are seen.

// File: rtl/dma_pkt_splitter.sv
module dma_pkt_splitter #(
  parameter int ADDR_W  = 32,
  parameter int MAX_PKT = 4096,
  parameter int CHUNK   = 256,
  parameter int ALIGN   = 8,
  localparam int LEN_W   = $clog2(MAX_PKT) + 1,
  localparam int PIECE_W = $clog2(CHUNK) + 1,
  localparam int AL_W    = $clog2(ALIGN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [ADDR_W-1:0]  cmd_src_addr,
  input  logic [ADDR_W-1:0]  cmd_dst_addr,
  input  logic [LEN_W-1:0]   cmd_len,
  input  logic               cmd_src_ext,
  input  logic               cmd_dst_ext,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_src_addr,
  output logic [ADDR_W-1:0]  req_dst_addr,
  output logic [PIECE_W-1:0] req_len,
  output logic               req_last,
  output logic               err_flag
);

  logic              busy;
  logic              err_q;
  logic [ADDR_W-1:0] src_q;
  logic [ADDR_W-1:0] dst_q;
  logic [LEN_W-1:0]  rem_q;

  logic accept, len_bad, sram_bad, path_bad, bad, last;

  assign accept   = cmd_valid && !busy;
  assign len_bad  = (cmd_len == '0) || (cmd_len > LEN_W'(MAX_PKT));
  assign sram_bad = !cmd_dst_ext &&
                    ((|cmd_dst_addr[AL_W-1:0]) || (|cmd_len[AL_W-1:0]));
  assign path_bad = cmd_src_ext && !cmd_dst_ext && (|cmd_src_addr[AL_W-1:0]);
  assign bad      = len_bad || sram_bad || path_bad;
  assign last     = rem_q <= LEN_W'(CHUNK);

  assign cmd_ready    = !busy;
  assign req_valid    = busy;
  assign req_src_addr = src_q;
  assign req_dst_addr = dst_q;
  assign req_last     = last;
  assign req_len      = last ? rem_q[PIECE_W-1:0] : PIECE_W'(CHUNK);
  assign err_flag     = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      err_q <= 1'b0;
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
    end else if (accept) begin
      if (bad) begin
        err_q <= 1'b1;
      end else begin
        busy  <= 1'b1;
        src_q <= cmd_src_addr;
        dst_q <= cmd_dst_addr;
        rem_q <= cmd_len;
      end
    end else if (busy && req_ready) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        src_q <= src_q + ADDR_W'(CHUNK);
        dst_q <= dst_q + ADDR_W'(CHUNK);
        rem_q <= rem_q - LEN_W'(CHUNK);
      end
    end
  end

endmodule

// File: rtl/dma_pkt_splitter_chk.sv
module dma_pkt_splitter_chk #(
  parameter int ADDR_W  = 32,
  parameter int MAX_PKT = 4096,
  parameter int CHUNK   = 256,
  localparam int LEN_W   = $clog2(MAX_PKT) + 1,
  localparam int PIECE_W = $clog2(CHUNK) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [LEN_W-1:0]   cmd_len,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_src_addr,
  input logic [ADDR_W-1:0]  req_dst_addr,
  input logic [PIECE_W-1:0] req_len,
  input logic               req_last,
  input logic               err_flag
);

  // R1
  piece_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (req_len <= PIECE_W'(CHUNK)));

  // R10
  full_piece_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_last |-> req_len == PIECE_W'(CHUNK));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_last |=> req_valid &&
      (req_src_addr == $past(req_src_addr) + ADDR_W'(CHUNK)) &&
      (req_dst_addr == $past(req_dst_addr) + ADDR_W'(CHUNK)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_src_addr) &&
      $stable(req_dst_addr) && $stable(req_len) && $stable(req_last));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && req_valid));

  // R8
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R4
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_len == '0) |=> err_flag && !req_valid);

  // R3
  over_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_len > LEN_W'(MAX_PKT)) |=> err_flag && !req_valid);

endmodule

bind dma_pkt_splitter dma_pkt_splitter_chk #(
  .ADDR_W(ADDR_W), .MAX_PKT(MAX_PKT), .CHUNK(CHUNK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_len(cmd_len), .req_valid(req_valid), .req_ready(req_ready),
  .req_src_addr(req_src_addr), .req_dst_addr(req_dst_addr),
  .req_len(req_len), .req_last(req_last), .err_flag(err_flag)
);

// File: tb/dma_pkt_splitter_bench.sv
module dma_pkt_splitter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [31:0] cmd_src_addr = '0, cmd_dst_addr = '0;
  logic [12:0] cmd_len = '0;
  logic        cmd_src_ext = 1'b0, cmd_dst_ext = 1'b0;
  logic        req_valid, req_ready = 1'b0, req_last, err_flag;
  logic [31:0] req_src_addr, req_dst_addr;
  logic [8:0]  req_len;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  dma_pkt_splitter u_dma_pkt_splitter (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_src_addr(cmd_src_addr), .cmd_dst_addr(cmd_dst_addr), .cmd_len(cmd_len),
    .cmd_src_ext(cmd_src_ext), .cmd_dst_ext(cmd_dst_ext),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_src_addr(req_src_addr), .req_dst_addr(req_dst_addr),
    .req_len(req_len), .req_last(req_last), .err_flag(err_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; req_ready = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  function automatic bit expect_bad(input logic [31:0] s, input logic [31:0] d,
                                    input int len, input bit se, input bit de);
    if (len == 0 || len > 4096) return 1'b1;
    if (!de && ((d % 8) != 0 || (len % 8) != 0)) return 1'b1;
    if (se && !de && (s % 8) != 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run_pkt(input logic [31:0] s, input logic [31:0] d, input int len,
                         input bit se, input bit de, input string tag);
    bit bad = expect_bad(s, d, len, se, de);
    bit err_before = err_flag;
    int pieces = (len + 255) / 256;
    int k = 0, t = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_src_addr = s; cmd_dst_addr = d;
    cmd_len = 13'(len); cmd_src_ext = se; cmd_dst_ext = de; req_ready = 1'b0;
    @(posedge clk); #1 cmd_valid = 1'b0;
    @(negedge clk);
    if (bad) begin
      check(err_flag == 1'b1, {tag, " R8"}, "err_flag after reject", err_flag, 1);
      check(!req_valid && cmd_ready, {tag, " R8"}, "no request, ready again",
            {req_valid, cmd_ready}, 1);
    end else begin
      check(err_flag == err_before, tag, "err_flag unchanged", err_flag, err_before);
      while (k < pieces && t < 20000) begin
        logic [31:0] es = s + 32'(256 * k), ed = d + 32'(256 * k);
        int el = (k < pieces - 1) ? 256 : len - 256 * (pieces - 1);
        bit elast = (k == pieces - 1);
        if (!req_valid) begin
          check(1'b0, {tag, " R1"}, "missing piece", k, pieces);
          break;
        end
        check(req_src_addr == es && req_dst_addr == ed, {tag, " R2"},
              "piece address", req_src_addr, es);
        check(req_len == 9'(el) && req_last == elast, {tag, " R10"},
              "piece len/last", {req_last, req_len}, {elast, 9'(el)});
        check(!cmd_ready, "R9", "cmd_ready while busy", cmd_ready, 0);
        req_ready = (t % 3) != 2;
        t++;
        @(posedge clk); #1;
        if (req_ready) k++;
        @(negedge clk);
      end
      req_ready = 1'b0;
      // R1: piece count, e.g. 4095 bytes -> 16
      check(k == pieces && !req_valid && cmd_ready, {tag, " R1"},
            "piece count", k, pieces);
    end
  endtask

  initial begin
    wait (cyc >= 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R11
    check(cmd_ready && !req_valid && !err_flag, "R11", "reset state",
          {cmd_ready, req_valid, err_flag}, 3'b100);

    // R1 R6: every length, unaligned addresses, external to external
    for (int len = 1; len <= 4096; len++)
      run_pkt(32'h0000_1003 + 32'(len), 32'hFFFF_F001 + 32'(len * 3), len, 1'b1, 1'b1, "R6");
    run_pkt(32'h10, 32'h20, 4095, 1'b0, 1'b1, "R1");

    // R3
    do_reset(); run_pkt(32'h0, 32'h0, 4097, 1'b1, 1'b1, "R3");
    do_reset(); run_pkt(32'h0, 32'h0, 8191, 1'b0, 1'b0, "R3");
    do_reset(); run_pkt(32'h0, 32'h800, 4096, 1'b1, 1'b0, "R3");
    // R4, then R8: next command still accepted with the flag held
    do_reset(); run_pkt(32'h0, 32'h0, 0, 1'b0, 1'b1, "R4");
    run_pkt(32'h5, 32'h7, 300, 1'b0, 1'b1, "R8");
    check(err_flag, "R8", "flag still set", err_flag, 1);

    // R5 R6 R7: all media pairs against all low offsets
    for (int se = 0; se < 2; se++)
      for (int de = 0; de < 2; de++)
        for (int so = 0; so < 8; so++)
          for (int dof = 0; dof < 8; dof++)
            for (int li = 0; li < 3; li++) begin
              int len = (li == 0) ? 16 : (li == 1) ? 21 : 264;
              string tag = de ? "R6" : (se ? "R7" : "R5");
              do_reset();
              run_pkt(32'h4000 + 32'(so), 32'h9000 + 32'(dof), len, se[0], de[0], tag);
            end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule